// File: doc/BRIEF.md
# Hibernate Power Sequencer

This block is a supervisory state machine that puts a reconfigurable logic device into a sleep state with no core power and brings it back out. To go to sleep it first pulls the device's active-low program line low, which makes every device pin high impedance. It then waits until the device reports both its open-drain init status and its configuration-done status low. Only then does it remove the core and auxiliary rails, and any I/O bank rail whose qualifier input says the bank's pins are held low or their drivers are disabled.

On wake it brings the rails back in a fixed order, with a settle delay after each step: core first, then auxiliary, then the I/O banks that were switched off. Because of this order the core rail always reports good before the last rail starts to ramp. The program line stays low until every removed rail reports good. After it is released, the block waits for init to go high and then for configuration-done to go high, and only then reports ready.

Every wait has a timeout. When a timeout expires the block enters a fault state that it leaves only through reset. All device status inputs pass through a two-stage synchronizer. Requests are sampled every cycle, and the requester holds a request until the block acts on it.

Top module: `hib_seq_ctrl`

## Requirements
- R1: After reset the block shows `ready`=1, `prog_n`=1, `en_core`=1, `en_aux`=1, all `en_bank` bits 1, `asleep`=0 and `fault`=0.
- R2: A sleep request in the ready state drives `prog_n` low on the next clock edge. No rail enable falls while `prog_n` is high, and the rails stay enabled until the synchronized init and done statuses both read low.
- R3: When sleep is reached (`asleep`=1), `en_core` and `en_aux` are 0. Bit i of `en_bank` is 0 exactly when bit i of `bank_off_ok` was 1 at that moment; every other bank stays enabled.
- R4: On wake, `en_core` rises first. `en_aux` rises only after the core power-good is high and a settle delay has passed. Bank enables rise last, only after both core and auxiliary power-good are high.
- R5: `prog_n` rises only after every rail that was removed reports power-good.
- R6: After `prog_n` is released, `ready` rises only after init status and then done status have gone high.
- R7: If any wait state lasts TMO cycles, the block enters fault: `fault`=1, `prog_n`=0 and `ready`=0. It stays there, ignoring sleep and wake requests, until reset.
- R8: A sleep request made during a wake sequence is remembered. Once ready is reached, the block starts the sleep sequence with no further request.
- R9: A wake request in the ready state has no effect on any output.
- R10: Status inputs pass through two synchronizer stages. When init and done both drop while the block waits in its drain state, `en_core` falls on the third clock edge after the change.
- R11: A wake request in sleep is accepted only after the synchronized core and auxiliary power-good flags both read low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter sleep (held by the requester) |
| wake_req | input | 1 | Request to leave sleep (held until `en_core` rises) |
| pg_core | input | 1 | Core rail power-good (asynchronous) |
| pg_aux | input | 1 | Auxiliary rail power-good (asynchronous) |
| pg_bank | input | NB | Per-bank I/O rail power-good (asynchronous) |
| bank_off_ok | input | NB | Per-bank permission to switch that rail off in sleep |
| init_st | input | 1 | Device open-drain init status |
| done_st | input | 1 | Device configuration-done status |
| en_core | output | 1 | Core rail switch enable |
| en_aux | output | 1 | Auxiliary rail switch enable |
| en_bank | output | NB | Per-bank I/O rail switch enables |
| prog_n | output | 1 | Active-low program/reset line to the device |
| asleep | output | 1 | Sleep reached |
| ready | output | 1 | Device awake and configured |
| fault | output | 1 | Sticky timeout error |

## Verification
The bench wraps the block in a device model with randomized rail ramp delays and random bank qualifier masks, and checks every edge of the rail order as it happens. A design that raised auxiliary before core power-good, released the program line early or removed rails before the drain completed would show up as an ordering miss. Directed cases cover these failure modes:
- A lost queued sleep request leaves the block parked in ready.
- A wrong synchronizer depth moves the rail-off edge away from the third clock.
- A stuck-done device or a dead auxiliary rail must end in a sticky fault that ignores later requests.

// File: rtl/hib_pkg.sv
package hib_pkg;
   typedef enum logic [3:0] {
      S_READY, S_DRAIN, S_SLEEP,
      S_WCORE, S_SCORE, S_WAUX, S_SAUX, S_WBANK, S_SBANK,
      S_WINIT, S_WDONE, S_FAULT
   } hib_state_t;
endpackage

// File: rtl/hib_sync.sv
module hib_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("hib_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= RST_VAL;
         else if (i == 0) stg[i] <= d;
         else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hib_tick.sv
module hib_tick #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] cnt
);
   if (CW < 2) begin : g_bad
      $error("hib_tick width too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (clr) cnt <= '0;
      else if (cnt != '1) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/hib_seq_ctrl.sv
module hib_seq_ctrl
   import hib_pkg::*;
#(
   parameter int NB = 4,
   parameter int SETTLE = 4,
   parameter int TMO = 200,
   parameter int SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep_req,
   input  logic          wake_req,
   input  logic          pg_core,
   input  logic          pg_aux,
   input  logic [NB-1:0] pg_bank,
   input  logic [NB-1:0] bank_off_ok,
   input  logic          init_st,
   input  logic          done_st,
   output logic          en_core,
   output logic          en_aux,
   output logic [NB-1:0] en_bank,
   output logic          prog_n,
   output logic          asleep,
   output logic          ready,
   output logic          fault
);
   localparam int LIM = (SETTLE > TMO) ? SETTLE : TMO;
   localparam int CW  = $clog2(LIM + 1) + 1;
   localparam int SW  = 2*NB + 4;
   localparam logic [SW-1:0] SRST = {{NB{1'b0}}, {NB{1'b1}}, 4'b1111};

   if (NB < 1) begin : g_bad_nb
      $error("NB must be at least 1");
   end
   if (SETTLE < 1) begin : g_bad_settle
      $error("SETTLE must be at least 1");
   end
   if (TMO <= SETTLE) begin : g_bad_tmo
      $error("TMO must exceed SETTLE");
   end

   logic [SW-1:0] raw_v, syn_v;
   logic          core_s, aux_s, init_s, done_s;
   logic [NB-1:0] pgb_s, bok_s;

   assign raw_v = {bank_off_ok, pg_bank, done_st, init_st, pg_aux, pg_core};

   hib_sync #(.W(SW), .STAGES(SYNC), .RST_VAL(SRST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v)
   );

   assign core_s = syn_v[0];
   assign aux_s  = syn_v[1];
   assign init_s = syn_v[2];
   assign done_s = syn_v[3];
   assign pgb_s  = syn_v[4 +: NB];
   assign bok_s  = syn_v[4+NB +: NB];

   hib_state_t    state, state_d;
   logic [CW-1:0] cnt;
   logic          settled, expired, pend;
   logic [NB-1:0] off_mask;

   hib_tick #(.CW(CW)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(state_d != state), .cnt(cnt)
   );

   assign settled = (cnt >= CW'(SETTLE - 1));
   assign expired = (cnt >= CW'(TMO - 1));

   always_comb begin
      state_d = state;
      unique case (state)
         S_READY: if (sleep_req || pend) state_d = S_DRAIN;
         S_DRAIN: if (!init_s && !done_s) state_d = S_SLEEP;
                  else if (expired) state_d = S_FAULT;
         S_SLEEP: if (wake_req && !core_s && !aux_s) state_d = S_WCORE;
         S_WCORE: if (core_s) state_d = S_SCORE;
                  else if (expired) state_d = S_FAULT;
         S_SCORE: if (settled) state_d = S_WAUX;
         S_WAUX:  if (aux_s) state_d = S_SAUX;
                  else if (expired) state_d = S_FAULT;
         S_SAUX:  if (settled) state_d = (|off_mask) ? S_WBANK : S_WINIT;
         S_WBANK: if (&pgb_s) state_d = S_SBANK;
                  else if (expired) state_d = S_FAULT;
         S_SBANK: if (settled) state_d = S_WINIT;
         S_WINIT: if (init_s) state_d = S_WDONE;
                  else if (expired) state_d = S_FAULT;
         S_WDONE: if (done_s) state_d = S_READY;
                  else if (expired) state_d = S_FAULT;
         default: state_d = S_FAULT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_READY;
         en_core  <= 1'b1;
         en_aux   <= 1'b1;
         en_bank  <= '1;
         prog_n   <= 1'b1;
         off_mask <= '0;
         pend     <= 1'b0;
      end else begin
         state <= state_d;
         if (state >= S_WCORE && state <= S_WDONE && sleep_req) pend <= 1'b1;
         if (state == S_READY && state_d == S_DRAIN) begin
            prog_n <= 1'b0;
            pend   <= 1'b0;
         end
         if (state == S_DRAIN && state_d == S_SLEEP) begin
            en_core  <= 1'b0;
            en_aux   <= 1'b0;
            en_bank  <= ~bok_s;
            off_mask <= bok_s;
         end
         if (state == S_SLEEP && state_d == S_WCORE) en_core <= 1'b1;
         if (state == S_SCORE && state_d == S_WAUX)  en_aux  <= 1'b1;
         if (state == S_SAUX  && state_d == S_WBANK) en_bank <= '1;
         if (state != S_WINIT && state_d == S_WINIT) prog_n  <= 1'b1;
         if (state_d == S_FAULT) prog_n <= 1'b0;
      end
   end

   assign asleep = (state == S_SLEEP);
   assign ready  = (state == S_READY);
   assign fault  = (state == S_FAULT);

   // R2
   rails_after_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_core) |-> !prog_n);
   // R4
   aux_after_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_aux) |-> (en_core && core_s));
   // R4
   bank_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(en_bank & ~$past(en_bank))) |-> (en_aux && aux_s && core_s));
   // R5
   prog_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_n) |-> (en_core && en_aux && (&en_bank)));
   // R6
   ready_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (done_s && init_s && prog_n));
   // R7
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (fault && !prog_n && !ready));
endmodule

// File: tb/hib_seq_ctrl_bench.sv
module hib_seq_ctrl_bench;
   localparam int NB = 4;
   localparam int SETTLE = 4;
   localparam int TMO = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b0, wake_req = 1'b0;
   logic pg_core = 1'b1, pg_aux = 1'b1;
   logic [NB-1:0] pg_bank = '1, bank_off_ok = '0;
   logic init_st, done_st;
   logic en_core, en_aux, prog_n, asleep, ready, fault;
   logic [NB-1:0] en_bank;

   // device model state
   logic m_init = 1'b1, m_done = 1'b1;
   logic man = 1'b0, man_init = 1'b1, man_done = 1'b1;
   logic kill_aux = 1'b0, stick_done = 1'b0;
   int   dly_core = 2, dly_aux = 3, dly_bank = 1, dly_init = 4, dly_cfg = 6;
   int   cc = 0, ca = 0, ic = 0;
   int   cb [NB];

   int nchk = 0, nfail = 0;
   logic mon_on = 1'b0;

   always #2 clk = ~clk;

   assign init_st = man ? man_init : m_init;
   assign done_st = man ? man_done : m_done;

   hib_seq_ctrl #(.NB(NB), .SETTLE(SETTLE), .TMO(TMO)) u_hib_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .pg_core(pg_core), .pg_aux(pg_aux), .pg_bank(pg_bank),
      .bank_off_ok(bank_off_ok), .init_st(init_st), .done_st(done_st),
      .en_core(en_core), .en_aux(en_aux), .en_bank(en_bank), .prog_n(prog_n),
      .asleep(asleep), .ready(ready), .fault(fault)
   );

   function automatic logic [NB-1:0] exp_bank_en(input logic [NB-1:0] qual);
      return ~qual;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // device model: rails ramp after random delays, drop at once when disabled
   always @(negedge clk) begin
      if (!en_core) begin pg_core <= 1'b0; cc <= 0; end
      else if (cc >= dly_core) pg_core <= 1'b1;
      else cc <= cc + 1;
      if (!en_aux || kill_aux) begin pg_aux <= 1'b0; ca <= 0; end
      else if (ca >= dly_aux) pg_aux <= 1'b1;
      else ca <= ca + 1;
      for (int i = 0; i < NB; i++) begin
         if (!en_bank[i]) begin pg_bank[i] <= 1'b0; cb[i] <= 0; end
         else if (cb[i] >= dly_bank) pg_bank[i] <= 1'b1;
         else cb[i] <= cb[i] + 1;
      end
      if (!prog_n || !pg_core || !pg_aux || !(&pg_bank)) begin
         m_init <= 1'b0; m_done <= stick_done; ic <= 0;
      end else if (!m_init) begin
         if (ic >= dly_init) m_init <= 1'b1; else ic <= ic + 1;
      end else if (!m_done) begin
         if (ic >= dly_init + dly_cfg) m_done <= 1'b1; else ic <= ic + 1;
      end
   end

   // ordering monitor
   logic p_core = 1'b1, p_aux = 1'b1, p_prog = 1'b1, p_ready = 1'b1;
   logic [NB-1:0] p_bank = '1;
   always @(negedge clk) begin
      if (mon_on) begin
         if (p_core && !en_core) chk(!prog_n, "R2", "core off while prog_n high", prog_n, 0);
         if (!p_aux && en_aux) chk(pg_core, "R4", "aux rose before core good", pg_core, 1);
         if (|(en_bank & ~p_bank))
            chk(pg_core && pg_aux, "R4", "bank rose before core/aux good", {pg_core, pg_aux}, 3);
         if (!p_prog && prog_n)
            chk(pg_core && pg_aux && (&pg_bank), "R5", "prog_n released early",
                {pg_core, pg_aux, pg_bank}, {2'b11, {NB{1'b1}}});
         if (!p_ready && ready)
            chk(init_st && done_st, "R6", "ready before init/done", {init_st, done_st}, 3);
      end
      p_core = en_core; p_aux = en_aux; p_prog = prog_n; p_ready = ready; p_bank = en_bank;
   end

   task automatic do_reset();
      mon_on = 1'b0;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
   endtask

   task automatic do_sleep();
      @(negedge clk) sleep_req = 1'b1;
      @(negedge clk) sleep_req = 1'b0;
      for (int i = 0; i < 2000 && !asleep; i++) @(negedge clk);
   endtask

   task automatic do_wake();
      @(negedge clk) wake_req = 1'b1;
      for (int i = 0; i < 2000 && !en_core; i++) @(negedge clk);
      wake_req = 1'b0;
      for (int i = 0; i < 3000 && !ready && !fault; i++) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [NB-1:0] qual;
      void'($urandom(32'd4242));
      for (int i = 0; i < NB; i++) cb[i] = 0;
      do_reset();
      repeat (6) @(negedge clk);

      // R1 reset state
      chk(ready && prog_n && en_core && en_aux && (&en_bank) && !asleep && !fault,
          "R1", "reset outputs", {ready, prog_n, en_core, en_aux, asleep, fault}, 6'b111100);

      // R9 wake in ready ignored
      wake_req = 1'b1;
      repeat (6) @(negedge clk);
      wake_req = 1'b0;
      repeat (3) @(negedge clk);
      chk(ready && prog_n && en_core && en_aux && (&en_bank) && !asleep,
          "R9", "wake in ready changed outputs", {ready, prog_n, asleep}, 3'b110);

      // random scenarios
      for (int s = 0; s < 8; s++) begin
         qual = NB'($urandom);
         if (s == 0) qual = '0;
         if (s == 1) qual = '1;
         bank_off_ok = qual;
         dly_core = $urandom_range(0, 6); dly_aux = $urandom_range(0, 6);
         dly_bank = $urandom_range(0, 6); dly_init = $urandom_range(1, 10);
         dly_cfg = $urandom_range(1, 20);
         repeat (4) @(negedge clk);
         do_sleep();
         chk(asleep, "R3", "sleep reached", asleep, 1);
         chk(!en_core && !en_aux, "R3", "core/aux off in sleep", {en_core, en_aux}, 0);
         chk(en_bank == exp_bank_en(qual), "R3", "bank enables in sleep",
             en_bank, exp_bank_en(qual));
         chk(!prog_n, "R2", "prog_n low in sleep", prog_n, 0);
         repeat ($urandom_range(1, 10)) @(negedge clk);
         do_wake();
         chk(ready && prog_n && en_core && en_aux && (&en_bank) && !fault,
             "R6", "wake ends ready", {ready, prog_n, fault}, 3'b110);
      end

      // R11: wake raised at the first sleep cycle waits for rails to read down
      bank_off_ok = '0;
      repeat (4) @(negedge clk);
      do_sleep();
      wake_req = 1'b1;
      @(negedge clk);
      chk(!en_core, "R11", "wake taken before rails read down", en_core, 0);
      for (int i = 0; i < 2000 && !en_core; i++) @(negedge clk);
      wake_req = 1'b0;
      for (int i = 0; i < 3000 && !ready; i++) @(negedge clk);
      chk(ready, "R11", "wake eventually accepted", ready, 1);

      // R10 synchronizer latency with directly driven status
      man = 1'b1; man_init = 1'b1; man_done = 1'b1;
      repeat (3) @(negedge clk);
      @(negedge clk) sleep_req = 1'b1;
      @(negedge clk) sleep_req = 1'b0;
      chk(!prog_n, "R2", "prog_n low one edge after request", prog_n, 0);
      repeat (5) @(negedge clk);
      chk(en_core, "R2", "rails kept while status high", en_core, 1);
      man_init = 1'b0; man_done = 1'b0;
      repeat (2) @(negedge clk);
      chk(en_core, "R10", "core off too early", en_core, 1);
      @(negedge clk);
      chk(!en_core, "R10", "core off on third edge", en_core, 0);
      man = 1'b0;
      repeat (6) @(negedge clk);
      do_wake();
      chk(ready, "R6", "ready after manual sleep", ready, 1);

      // R8 queued sleep during wake
      do_sleep();
      @(negedge clk) wake_req = 1'b1;
      for (int i = 0; i < 2000 && !en_core; i++) @(negedge clk);
      wake_req = 1'b0;
      sleep_req = 1'b1;
      @(negedge clk) sleep_req = 1'b0;
      for (int i = 0; i < 3000 && !ready; i++) @(negedge clk);
      chk(ready, "R8", "wake completes before queued sleep", ready, 1);
      for (int i = 0; i < 3000 && !asleep; i++) @(negedge clk);
      chk(asleep, "R8", "queued sleep acted on", asleep, 1);
      do_wake();
      chk(ready, "R8", "wake after queued sleep", ready, 1);

      // R7 fault on dead auxiliary rail
      do_sleep();
      kill_aux = 1'b1;
      @(negedge clk) wake_req = 1'b1;
      for (int i = 0; i < 2000 && !en_core; i++) @(negedge clk);
      wake_req = 1'b0;
      for (int i = 0; i < TMO + 200 && !fault; i++) @(negedge clk);
      chk(fault && !prog_n && !ready, "R7", "aux timeout fault", {fault, prog_n, ready}, 3'b100);
      wake_req = 1'b1; sleep_req = 1'b1;
      repeat (10) @(negedge clk);
      wake_req = 1'b0; sleep_req = 1'b0;
      repeat (5) @(negedge clk);
      chk(fault && !prog_n && !ready && !asleep, "R7", "fault sticky under requests",
          {fault, prog_n, ready, asleep}, 4'b1000);
      kill_aux = 1'b0;

      // R7 fault on device that never drops done
      do_reset();
      repeat (10) @(negedge clk);
      chk(ready, "R1", "ready after second reset", ready, 1);
      stick_done = 1'b1;
      @(negedge clk) sleep_req = 1'b1;
      @(negedge clk) sleep_req = 1'b0;
      for (int i = 0; i < TMO + 200 && !fault; i++) @(negedge clk);
      chk(fault && !prog_n, "R7", "drain timeout fault", {fault, prog_n}, 2'b10);
      chk(en_core && en_aux, "R2", "rails kept when done stuck high", {en_core, en_aux}, 3);
      stick_done = 1'b0;

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule